// File: doc/BRIEF.md
# Background Calibration Sequencer with Correction Table

This block runs the digital side of background calibration for a small interstage DAC in a pipelined converter stage. The DAC has `N_UNIT` nominally equal unit elements and one spare element. A rotating one-hot selector puts exactly one of these elements into calibration mode. The other elements keep doing normal conversion work, so conversion never stops. An external mismatch extractor measures the selected element over a session. When the session ends, the extractor pulses `session_done` and presents the measured error on `mis_word`. The block stores that word for the element being calibrated and moves the selector on to the next element.

From the stored errors the block forms, combinationally, one integral-nonlinearity value for each sub-converter code. The value for code c is the signed sum of the errors of the elements that code c switches to the reference. Those are the first c elements, in ascending index order, that are not in calibration. Every cycle, the raw output word is registered together with its sub-converter code. One cycle later the looked-up table value is subtracted from the word. The result is saturated to the output width and appears beside the delayed code.

Top module: `bgcal_seq`

## Requirements
- R1: `cal_sel` is always one-hot over the `N_UNIT`+1 elements. After reset, bit 0 is set (element 0 in calibration).
- R2: `cal_sel` changes only in the cycle after `session_done` is high. It then moves to the next higher bit, and from the top bit (the spare element) it wraps to bit 0.
- R3: When `session_done` is high, `mis_word` is stored for the element whose `cal_sel` bit is set in that same cycle. The stored value takes effect in the correction from the next cycle on.
- R4: The correction value for code c is the signed sum of the stored errors of the first c elements, in ascending index, whose `cal_sel` bit is clear. Code 0 gives zero. Any code above `N_UNIT` is treated as `N_UNIT`.
- R5: `corr_word` equals the `raw_word` of the previous cycle minus the correction value for the `sub_code` of that same cycle. `corr_code` equals the previous cycle's `sub_code`. A new word is accepted every cycle.
- R6: Arithmetic is two's complement. A difference above the largest signed `DATA_W` value gives that largest value, and a difference below the smallest gives the smallest.
- R7: Synchronous reset clears every stored error to zero and clears the pipeline, so that `corr_word` and `corr_code` read 0.
- R8: A word presented with code 0 leaves the block unchanged, whatever errors are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| session_done | input | 1 | One-cycle strobe from the extractor at the end of a session |
| mis_word | input | MIS_W | Signed measured error of the element under calibration |
| raw_word | input | DATA_W | Signed raw converter output word |
| sub_code | input | CODE_W | Stage sub-converter code that goes with `raw_word` |
| cal_sel | output | N_UNIT+1 | One-hot element-in-calibration select |
| corr_word | output | DATA_W | Corrected signed output word, one cycle late |
| corr_code | output | CODE_W | `sub_code` delayed to align with `corr_word` |

## Verification
Five sessions first load distinct signed errors for all elements. The same raw word is then applied with every code from 0 to 4. The resulting sequence of differences reveals which elements each code sums, and shows that the calibrating element is skipped. Further vectors drive words near both rails in opposite directions, to separate saturation from wraparound, and an out-of-range code, to confirm clamping. After that, one more session moves the calibrating element. The new corrections prove that both the stored error and the choice of skipped element followed the write. A reset afterwards confirms that the errors are wiped and the selector returns to bit 0.

// File: rtl/bgcal_seq.sv
module bgcal_seq #(
  parameter int N_UNIT = 4,
  parameter int DATA_W = 16,
  parameter int MIS_W  = 10,
  parameter int CODE_W = $clog2(N_UNIT + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     session_done,
  input  logic signed [MIS_W-1:0]  mis_word,
  input  logic signed [DATA_W-1:0] raw_word,
  input  logic [CODE_W-1:0]        sub_code,
  output logic [N_UNIT:0]          cal_sel,
  output logic signed [DATA_W-1:0] corr_word,
  output logic [CODE_W-1:0]        corr_code
);
  localparam int N_EL   = N_UNIT + 1;
  localparam int SUM_W  = MIS_W + $clog2(N_EL);
  localparam int DIFF_W = ((DATA_W > SUM_W) ? DATA_W : SUM_W) + 1;
  localparam logic signed [DIFF_W-1:0] SAT_HI =
    {{(DIFF_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [DIFF_W-1:0] SAT_LO =
    {{(DIFF_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic [N_EL-1:0]          sel_q;
  logic signed [MIS_W-1:0]  err_q [N_EL];
  logic signed [SUM_W-1:0]  tbl [N_EL];
  logic signed [DATA_W-1:0] raw_q;
  logic [CODE_W-1:0]        code_q;
  logic [CODE_W-1:0]        code_eff;
  logic signed [DIFF_W-1:0] diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= N_EL'(1);
      for (int e = 0; e < N_EL; e++) err_q[e] <= '0;
    end else if (session_done) begin
      sel_q <= {sel_q[N_EL-2:0], sel_q[N_EL-1]};
      for (int e = 0; e < N_EL; e++)
        if (sel_q[e]) err_q[e] <= mis_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      code_q <= '0;
    end else begin
      raw_q  <= raw_word;
      code_q <= sub_code;
    end
  end

  always_comb begin
    for (int c = 0; c < N_EL; c++) begin
      int k;
      k = 0;
      tbl[c] = '0;
      for (int e = 0; e < N_EL; e++) begin
        if (!sel_q[e]) begin
          if (k < c) tbl[c] = tbl[c] + SUM_W'(err_q[e]);
          k = k + 1;
        end
      end
    end
  end

  assign code_eff = (code_q > CODE_W'(N_UNIT)) ? CODE_W'(N_UNIT) : code_q;
  assign diff     = DIFF_W'(raw_q) - DIFF_W'(tbl[code_eff]);

  assign corr_word = (diff > SAT_HI) ? DATA_W'(SAT_HI) :
                     (diff < SAT_LO) ? DATA_W'(SAT_LO) : DATA_W'(diff);
  assign corr_code = code_q;
  assign cal_sel   = sel_q;
endmodule

// File: rtl/bgcal_seq_chk.sv
module bgcal_seq_chk #(
  parameter int N_UNIT = 4,
  parameter int DATA_W = 16,
  parameter int CODE_W = 3
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     session_done,
  input logic signed [DATA_W-1:0] raw_word,
  input logic [CODE_W-1:0]        sub_code,
  input logic [N_UNIT:0]          cal_sel,
  input logic signed [DATA_W-1:0] corr_word,
  input logic [CODE_W-1:0]        corr_code
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $countones(cal_sel) == 1); // R1

  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !session_done |=> $stable(cal_sel)); // R2

  AST_SEL_STEP: assert property (@(posedge clk) disable iff (rst)
    session_done |=> cal_sel == $past({cal_sel[N_UNIT-1:0], cal_sel[N_UNIT]})); // R2

  AST_CODE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> corr_code == $past(sub_code)); // R5

  AST_CODE0_PASS: assert property (@(posedge clk) disable iff (rst)
    sub_code == '0 |=> corr_word == $past(raw_word)); // R8
endmodule

bind bgcal_seq bgcal_seq_chk #(
  .N_UNIT(N_UNIT), .DATA_W(DATA_W), .CODE_W(CODE_W)
) chk_i (
  .clk(clk), .rst(rst), .session_done(session_done),
  .raw_word(raw_word), .sub_code(sub_code), .cal_sel(cal_sel),
  .corr_word(corr_word), .corr_code(corr_code)
);

// File: tb/bgcal_seq_tb_top.sv
`timescale 1ns/1ps
module bgcal_seq_tb_top;
  localparam int N_UNIT = 4;
  localparam int DATA_W = 16;
  localparam int MIS_W  = 10;
  localparam int CODE_W = 3;
  localparam int NV     = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic session_done = 1'b0;
  logic signed [MIS_W-1:0]  mis_word = '0;
  logic signed [DATA_W-1:0] raw_word = '0;
  logic [CODE_W-1:0]        sub_code = '0;
  logic [N_UNIT:0]          cal_sel;
  logic signed [DATA_W-1:0] corr_word;
  logic [CODE_W-1:0]        corr_code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bgcal_seq #(.N_UNIT(N_UNIT), .DATA_W(DATA_W), .MIS_W(MIS_W), .CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst(rst), .session_done(session_done), .mis_word(mis_word),
    .raw_word(raw_word), .sub_code(sub_code), .cal_sel(cal_sel),
    .corr_word(corr_word), .corr_code(corr_code)
  );

  // Errors loaded: e0=+3 e1=-5 e2=+7 e3=+11 e4=-2; element 0 calibrating.
  // Active e1..e4 -> table c0=0 c1=-5 c2=2 c3=13 c4=11.
  // Fields: {raw, code, expected}
  localparam logic [2*DATA_W+CODE_W-1:0] VEC [NV] = '{
    {16'sd100,    3'd0, 16'sd100},     // R8
    {16'sd100,    3'd1, 16'sd105},     // R4
    {16'sd100,    3'd2, 16'sd98},      // R4
    {16'sd100,    3'd3, 16'sd87},      // R4
    {16'sd100,    3'd4, 16'sd89},      // R4
    {-16'sd50,    3'd4, -16'sd61},     // R5
    {16'sd32767,  3'd1, 16'sd32767},   // R6 upper rail
    {-16'sd32768, 3'd3, -16'sd32768},  // R6 lower rail
    {16'sd0,      3'd7, -16'sd11}      // R4 code clamp
  };

  task automatic chk_word(input string req, input logic signed [DATA_W-1:0] act,
                          input logic signed [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s word act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_bits(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s bits act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic signed [DATA_W-1:0] raw,
                       input logic [CODE_W-1:0] code, input logic signed [DATA_W-1:0] exp);
    @(negedge clk);
    raw_word = raw;
    sub_code = code;
    @(negedge clk);
    chk_word(req, corr_word, exp);
    chk_bits("R5", 8'(corr_code), 8'(code));
  endtask

  task automatic session(input logic signed [MIS_W-1:0] m);
    @(negedge clk);
    session_done = 1'b1;
    mis_word = m;
    @(negedge clk);
    session_done = 1'b0;
    mis_word = '0;
  endtask

  initial begin
    logic signed [MIS_W-1:0] errs [5];
    errs = '{10'sd3, -10'sd5, 10'sd7, 10'sd11, -10'sd2};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 / R1 reset state
    chk_word("R7", corr_word, 16'sd0);
    chk_bits("R7", 8'(corr_code), 8'd0);
    chk_bits("R1", 8'(cal_sel), 8'b00001);
    // R2: no strobe, no movement
    repeat (4) @(negedge clk);
    chk_bits("R2", 8'(cal_sel), 8'b00001);
    // R3 / R2: load all five elements, walking the selector
    for (int i = 0; i < 5; i++) begin
      session(errs[i]);
      chk_bits("R2", 8'(cal_sel), 8'((1 << ((i + 1) % 5))));
    end
    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [2*DATA_W+CODE_W-1:0] w;
      w = VEC[v];
      apply("R4", w[2*DATA_W+CODE_W-1 -: DATA_W], w[DATA_W+CODE_W-1 -: CODE_W],
            w[DATA_W-1:0]);
    end
    // R3: rewrite element 0 to +20; element 1 now calibrating.
    // Active e0,e2,e3,e4 -> c1=20 c2=27 c3=38 c4=36
    session(10'sd20);
    chk_bits("R2", 8'(cal_sel), 8'b00010);
    apply("R3", 16'sd0, 3'd1, -16'sd20);
    apply("R3", 16'sd0, 3'd2, -16'sd27);
    apply("R4", 16'sd0, 3'd4, -16'sd36);
    apply("R8", 16'sd1234, 3'd0, 16'sd1234);
    // R6: negative table pushes up toward rail (none here), check lower rail with positive table
    apply("R6", -16'sd32760, 3'd3, -16'sd32768);
    // R7: reset wipes errors and selector
    @(negedge clk);
    rst = 1'b1;
    raw_word = 16'sd10;
    sub_code = 3'd4;
    @(negedge clk);
    rst = 1'b0;
    chk_bits("R1", 8'(cal_sel), 8'b00001);
    @(negedge clk);
    chk_word("R7", corr_word, 16'sd10);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule